// File: doc/BRIEF.md
# Multi-Trigger Interrupt Controller

This block collects up to 32 interrupt sources and turns them into two request lines for a processor, plus a wake line. Each source picks its own trigger condition through a three-bit code spread across three configuration registers: rising edge, falling edge, either edge, active-high level, active-low level, or off. Source inputs are synchronized before any detection. Rising and falling edges are kept in two separate capture registers, and each one stays there until software clears it.

Software uses a small register port with a single-cycle write strobe and a combinational read. Most control registers have one address that sets bits and another that clears bits. A 1 in the write data acts on that bit and a 0 leaves it alone, so a single source can be changed without a read-modify-write. A mask bit enables each source. An assign bit sends the source to request line 0 or request line 1. A wake bit lets the source's raw event drive the wake output. For each request line there is a read-only pending register that shows which sources are driving that line.

Top module: `multi_trigger_intc`

## Requirements
- R1: After reset, every configuration, source, wake, mask and capture bit and the test register read 0, every assign bit reads 1, and req0, req1 and wake are low.
- R2: The address is {register index[5:2], operation[1:0]}. The operation is 0 for set, 1 for clear and 2 for read. Indices 0 to 6 are cfg0, cfg1, cfg2, source, assign, wake and mask. Set ORs the write data into the register, clear removes the 1-bits of the write data, and read returns the register. Write data of zero changes nothing. Operation 3 and unused indices read as 0.
- R3: The trigger code is {cfg2,cfg1,cfg0} per bit: 001 rising edge, 010 falling edge, 011 either edge, 101 active-high level, 110 active-low level. Codes 000, 100 and 111 disable the source, and a disabled source never captures and never pends.
- R4: Each input passes through two flops before detection. For a level mode, pending follows an input change at the second clock edge. For an edge mode, the capture bit and pending are set at the third clock edge. An edge is captured only if the source's code selects that edge.
- R5: The rising capture register (index 7: clear address 29, read address 30) and the falling capture register (index 8: clear address 33, read address 34) keep their bits until 1s are written to their own clear address. Clearing one register leaves the other unchanged.
- R6: A source with mask 0 adds nothing to either pending register or request line. Its capture bits are kept and count again once the mask is set.
- R7: A pending source with assign 1 drives req0. A pending source with assign 0 drives req1. Each request line is the OR of its pending bits.
- R8: Pending bit = mask AND (an edge mode with that edge's capture bit set, OR high-level mode with the synchronized input at 1, OR low-level mode with it at 0). The request-0 pending register reads at address 38, and the request-1 pending register reads at address 42.
- R9: wake is the OR, over sources whose wake bit is 1, of the raw event. For edges the raw event is a one-cycle pulse in the cycle after the second flop changes. For levels it is the active level.
- R10: The test register is written at address 44 and read at address 46. Its value does not affect the interrupt function, and 0 selects normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Asynchronous interrupt source inputs |
| bus_addr | input | 6 | Register address {index, operation} |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Combinational read data |
| req0 | output | 1 | Request line 0 |
| req1 | output | 1 | Request line 1 |
| wake | output | 1 | Wake event output |

## Verification
The edge-mode wake pulse is the hardest behaviour to reach from the ports. It is high for one cycle only, two edges after the input moves, and it is seen nowhere else. The bench drives each input change at a falling clock edge and counts exactly two rising edges before it samples wake. It then samples the capture and pending registers one edge later. All eight trigger codes are swept on different bit positions. Each code has rise and fall stimulus and alternates between the two request lines, and the expected values come from the code arithmetic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [1:0] OP_SET = 2'd0;
  localparam logic [1:0] OP_CLR = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;

  localparam logic [3:0] IDX_CFG0  = 4'd0;
  localparam logic [3:0] IDX_CFG1  = 4'd1;
  localparam logic [3:0] IDX_CFG2  = 4'd2;
  localparam logic [3:0] IDX_SRC   = 4'd3;
  localparam logic [3:0] IDX_ASG   = 4'd4;
  localparam logic [3:0] IDX_WAKE  = 4'd5;
  localparam logic [3:0] IDX_MASK  = 4'd6;
  localparam logic [3:0] IDX_RISE  = 4'd7;
  localparam logic [3:0] IDX_FALL  = 4'd8;
  localparam logic [3:0] IDX_PEND0 = 4'd9;
  localparam logic [3:0] IDX_PEND1 = 4'd10;
  localparam logic [3:0] IDX_TEST  = 4'd11;

  localparam int unsigned N_CTL = 7;

  function automatic logic mode_rise(input logic [2:0] c);
    return (c == 3'b001) || (c == 3'b011);
  endfunction

  function automatic logic mode_fall(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b011);
  endfunction

  function automatic logic mode_high(input logic [2:0] c);
    return c == 3'b101;
  endfunction

  function automatic logic mode_low(input logic [2:0] c);
    return c == 3'b110;
  endfunction
endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise_ev,
  output logic [N-1:0] fall_ev
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= raw[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
      end
    end
  end

  assign lvl     = sync_q;
  assign rise_ev = sync_q & ~prev_q;
  assign fall_ev = ~sync_q & prev_q;

  // R4: the synchronized level only ever takes the value the input had two edges earlier
  assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_q == $past(meta_q)));
endmodule

// File: rtl/irqc_setclr_reg.sv
module irqc_setclr_reg #(
  parameter int unsigned   N       = 32,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q & ~clr_v) | set_v;
  end

  // R2: a bit only moves when a set or clear strobe named it
  assert_bits_move_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~($past(set_v) | $past(clr_v))) == '0));
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] allow,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] cap
);
  logic [N-1:0] hit;
  assign hit = ev & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else        cap <= (cap & ~clr_v) | hit;
  end

  // R4: a newly captured bit needs an edge the mode selects
  assert_capture_needs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cap & ~$past(cap) & ~($past(ev) & $past(allow))) == '0));
  // R5: a captured bit falls only through its own clear strobe
  assert_capture_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cap) & ~cap & ~$past(clr_v)) == '0));
endmodule

// File: rtl/multi_trigger_intc.sv
module multi_trigger_intc
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              req0,
  output logic              req1,
  output logic              wake
);
  logic [3:0] idx;
  logic [1:0] op;
  assign idx = bus_addr[5:2];
  assign op  = bus_addr[1:0];

  // control registers with set/clear write pairs
  logic [N_SRC-1:0] ctl_q [N_CTL];
  logic [N_SRC-1:0] set_v [N_CTL];
  logic [N_SRC-1:0] clr_v [N_CTL];

  for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
    localparam logic [N_SRC-1:0] RV = (k == int'(IDX_ASG)) ? '1 : '0;
    assign set_v[k] = (bus_we && idx == 4'(k) && op == OP_SET) ? bus_wdata : '0;
    assign clr_v[k] = (bus_we && idx == 4'(k) && op == OP_CLR) ? bus_wdata : '0;
    irqc_setclr_reg #(.N(N_SRC), .RST_VAL(RV)) u_reg (
      .clk(clk), .rst_n(rst_n), .set_v(set_v[k]), .clr_v(clr_v[k]), .q(ctl_q[k])
    );
  end

  logic [N_SRC-1:0] cfg0, cfg1, cfg2, asg, wake_en, mask;
  assign cfg0    = ctl_q[IDX_CFG0[2:0]];
  assign cfg1    = ctl_q[IDX_CFG1[2:0]];
  assign cfg2    = ctl_q[IDX_CFG2[2:0]];
  assign asg     = ctl_q[IDX_ASG[2:0]];
  assign wake_en = ctl_q[IDX_WAKE[2:0]];
  assign mask    = ctl_q[IDX_MASK[2:0]];

  // test register: stored only
  logic [N_SRC-1:0] test_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= '0;
    else if (bus_we && idx == IDX_TEST && op == OP_SET) test_q <= bus_wdata;
  end

  // per-source mode decode
  logic [N_SRC-1:0] allow_rise, allow_fall, lvl_hi, lvl_lo;
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      allow_rise[i] = mode_rise({cfg2[i], cfg1[i], cfg0[i]});
      allow_fall[i] = mode_fall({cfg2[i], cfg1[i], cfg0[i]});
      lvl_hi[i]     = mode_high({cfg2[i], cfg1[i], cfg0[i]});
      lvl_lo[i]     = mode_low({cfg2[i], cfg1[i], cfg0[i]});
    end
  end

  // synchronizer and edge detection
  logic [N_SRC-1:0] lvl, rise_ev, fall_ev;
  irqc_sync_edge #(.N(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(src_in), .lvl(lvl), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  // capture registers
  logic [N_SRC-1:0] rise_clr, fall_clr, rise_cap, fall_cap;
  assign rise_clr = (bus_we && idx == IDX_RISE && op == OP_CLR) ? bus_wdata : '0;
  assign fall_clr = (bus_we && idx == IDX_FALL && op == OP_CLR) ? bus_wdata : '0;

  irqc_capture #(.N(N_SRC)) u_cap_rise (
    .clk(clk), .rst_n(rst_n), .ev(rise_ev), .allow(allow_rise), .clr_v(rise_clr), .cap(rise_cap)
  );
  irqc_capture #(.N(N_SRC)) u_cap_fall (
    .clk(clk), .rst_n(rst_n), .ev(fall_ev), .allow(allow_fall), .clr_v(fall_clr), .cap(fall_cap)
  );

  // pending, routing, wake
  logic [N_SRC-1:0] level_act, raw_event, pend, pend0, pend1;
  assign level_act = (lvl & lvl_hi) | (~lvl & lvl_lo);
  assign raw_event = (rise_ev & allow_rise) | (fall_ev & allow_fall) | level_act;
  assign pend      = mask & ((rise_cap & allow_rise) | (fall_cap & allow_fall) | level_act);
  assign pend0     = pend & asg;
  assign pend1     = pend & ~asg;
  assign req0      = |pend0;
  assign req1      = |pend1;
  assign wake      = |(wake_en & raw_event);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (op == OP_RD) begin
      if (idx <= IDX_MASK) bus_rdata = ctl_q[idx[2:0]];
      else begin
        case (idx)
          IDX_RISE:  bus_rdata = rise_cap;
          IDX_FALL:  bus_rdata = fall_cap;
          IDX_PEND0: bus_rdata = pend0;
          IDX_PEND1: bus_rdata = pend1;
          IDX_TEST:  bus_rdata = test_q;
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  // R6: with every mask bit clear neither request line can assert
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (!req0 && !req1));
  // R7: req0 needs a masked-in source assigned to it, req1 one assigned away
  assert_route_req0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req0 |-> ((mask & asg) != '0));
  assert_route_req1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req1 |-> ((mask & ~asg) != '0));
  // R9: wake needs some wake-enabled source
  assert_wake_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (wake_en != '0));
endmodule

// File: tb/sim_multi_trigger_intc.sv
`timescale 1ns/1ps
module sim_multi_trigger_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req0, req1, wake;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  multi_trigger_intc #(.N_SRC(32)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req0(req0), .req1(req1), .wake(wake)
  );

  function automatic logic [5:0] a_set(input int k); return 6'(k * 4);     endfunction
  function automatic logic [5:0] a_clr(input int k); return 6'(k * 4 + 1); endfunction
  function automatic logic [5:0] a_rd(input int k);  return 6'(k * 4 + 2); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, model;
    edges(3);
    rst_n = 1'b1;

    // R1: reset values
    for (int k = 0; k < 7; k++) begin
      rd(a_rd(k), d);
      chk("R1 reset ctl", d, (k == 4) ? 32'hFFFF_FFFF : 32'h0);
    end
    rd(6'd30, d); chk("R1 reset rise cap", d, 32'h0);
    rd(6'd34, d); chk("R1 reset fall cap", d, 32'h0);
    rd(6'd46, d); chk("R1 reset test", d, 32'h0);
    chk("R1 reset outputs", {29'h0, req0, req1, wake}, 32'h0);

    // R2: set/clear semantics on every control register
    for (int k = 0; k < 7; k++) begin
      wr(a_clr(k), 32'hFFFF_FFFF);
      rd(a_rd(k), d); chk("R2 clear all", d, 32'h0);
      wr(a_set(k), 32'h0000_F0F0);
      wr(a_set(k), 32'h0F00_0001);
      model = 32'h0F00_F0F1;
      rd(a_rd(k), d); chk("R2 set or", d, model);
      wr(a_clr(k), 32'h0000_1001);
      model = model & ~32'h0000_1001;
      rd(a_rd(k), d); chk("R2 clear bits", d, model);
      wr(a_set(k), 32'h0);
      wr(a_clr(k), 32'h0);
      rd(a_rd(k), d); chk("R2 zero write no effect", d, model);
      rd(6'(k * 4 + 3), d); chk("R2 op3 reads zero", d, 32'h0);
    end
    rd(6'd50, d); chk("R2 unused index reads zero", d, 32'h0);
    wr(a_clr(5), 32'hFFFF_FFFF);
    wr(a_clr(6), 32'hFFFF_FFFF);

    // R3 R4 R5 R7 R8 R9: sweep all trigger codes
    for (int c = 0; c < 8; c++) begin
      int s;
      logic [31:0] bitm, pexp;
      logic er, ef, eh, el, to0;
      s = (c * 4 + 3) % 32;
      bitm = 32'h1 << s;
      er = (c == 1) || (c == 3);
      ef = (c == 2) || (c == 3);
      eh = (c == 5);
      el = (c == 6);
      to0 = (c % 2 == 0);
      for (int k = 0; k < 3; k++) wr(a_clr(k), 32'hFFFF_FFFF);
      wr(a_clr(5), 32'hFFFF_FFFF);
      wr(a_clr(6), 32'hFFFF_FFFF);
      src_in = '0;
      edges(4);
      wr(6'd29, 32'hFFFF_FFFF);
      wr(6'd33, 32'hFFFF_FFFF);
      if (c[0]) wr(a_set(0), bitm);
      if (c[1]) wr(a_set(1), bitm);
      if (c[2]) wr(a_set(2), bitm);
      if (to0) wr(a_set(4), bitm); else wr(a_clr(4), bitm);
      wr(a_set(6), bitm);
      wr(a_set(5), bitm);

      // idle input low
      pexp = el ? bitm : 32'h0;
      rd(to0 ? 6'd38 : 6'd42, d); chk("R8 pending idle", d, pexp);
      rd(to0 ? 6'd42 : 6'd38, d); chk("R7 other line idle", d, 32'h0);
      chk("R7 req0 idle", {31'h0, req0}, {31'h0, el & to0});
      chk("R7 req1 idle", {31'h0, req1}, {31'h0, el & ~to0});

      // rising input
      @(negedge clk); src_in[s] = 1'b1;
      bus_addr = to0 ? 6'd38 : 6'd42;
      @(negedge clk); #0.5;
      chk("R4 one edge no level yet", bus_rdata, el ? bitm : 32'h0);
      @(negedge clk); #0.5;
      chk("R9 wake on rise", {31'h0, wake}, {31'h0, er | eh});
      chk("R4 level after two edges", bus_rdata & {32{eh | el}}, eh ? bitm : 32'h0);
      @(negedge clk); #0.5;
      pexp = (er | eh) ? bitm : 32'h0;
      chk("R8 pending after rise", bus_rdata, pexp);
      chk("R7 req after rise", {30'h0, req0, req1},
          {30'h0, (er | eh) & to0, (er | eh) & ~to0});
      rd(6'd30, d); chk("R3 rise capture", d, er ? bitm : 32'h0);
      rd(6'd34, d); chk("R3 no fall capture yet", d, 32'h0);

      // falling input
      @(negedge clk); src_in[s] = 1'b0;
      edges(2); #0.5;
      chk("R9 wake on fall", {31'h0, wake}, {31'h0, ef | el});
      edges(1);
      pexp = (er | ef | el) ? bitm : 32'h0;
      rd(to0 ? 6'd38 : 6'd42, d); chk("R8 pending after fall", d, pexp);
      rd(6'd34, d); chk("R3 fall capture", d, ef ? bitm : 32'h0);

      // clearing the fall capture keeps the rise capture
      wr(6'd33, 32'hFFFF_FFFF);
      rd(6'd30, d); chk("R5 rise kept after fall clear", d, er ? bitm : 32'h0);
      rd(6'd34, d); chk("R5 fall cleared", d, 32'h0);
      wr(6'd29, bitm);
      rd(6'd30, d); chk("R5 rise cleared", d, 32'h0);
      rd(to0 ? 6'd38 : 6'd42, d); chk("R8 pending after clears", d, el ? bitm : 32'h0);
    end

    // R6: masking keeps capture, blocks requests
    for (int k = 0; k < 3; k++) wr(a_clr(k), 32'hFFFF_FFFF);
    wr(a_clr(5), 32'hFFFF_FFFF);
    wr(a_clr(6), 32'hFFFF_FFFF);
    wr(6'd29, 32'hFFFF_FFFF);
    wr(6'd33, 32'hFFFF_FFFF);
    wr(a_set(0), 32'h1);
    wr(a_set(4), 32'h1);
    wr(a_set(6), 32'h1);
    @(negedge clk); src_in[0] = 1'b1;
    edges(4);
    chk("R7 req0 from source 0", {31'h0, req0}, 32'h1);
    wr(a_clr(6), 32'h1);
    chk("R6 masked req0", {31'h0, req0}, 32'h0);
    rd(6'd38, d); chk("R6 masked pending", d, 32'h0);
    rd(6'd30, d); chk("R6 capture kept while masked", d, 32'h1);
    wr(a_set(6), 32'h1);
    chk("R6 unmask restores req0", {31'h0, req0}, 32'h1);
    wr(a_clr(4), 32'h1);
    chk("R7 reroute to req1", {30'h0, req0, req1}, 32'h1);
    rd(6'd42, d); chk("R7 pending1 after reroute", d, 32'h1);

    // R10: test register
    wr(6'd44, 32'hA5A5_0F0F);
    rd(6'd46, d); chk("R10 test readback", d, 32'hA5A5_0F0F);
    chk("R10 req1 unaffected", {31'h0, req1}, 32'h1);
    wr(6'd44, 32'h0);
    rd(6'd46, d); chk("R10 test zero", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule